// File: doc/BRIEF.md
# Split-Section Decade Counter

This block is a decimal counter made of two sections that count independently. A binary section flips its single output bit on each high-to-low transition of its own count input. A five-state section steps a three-bit value through 0, 1, 2, 3, 4 and back to 0 on each high-to-low transition of a second count input. Used alone, the five-state section is a divide-by-5 whose top bit is high for one input period in five. Used alone, the binary section is a divide-by-2.

When the link input is high, the second section is stepped internally each time the binary bit falls. The four outputs then form an 8421 BCD digit that runs 0 through 9 and wraps to 0. Both count inputs are asynchronous pins. Each passes through a two-flop synchroniser and a falling-edge detector, so every state change happens on the rising edge of the single system clock.

A pair of clear inputs and a pair of preset inputs override counting. Each pair acts only when both of its members are high. The clear pair forces the digit to 0. The preset pair forces it to 9. Preset wins over clear.

Top module: `decade_ripple_ctr`

## Requirements
- R1: While `rst` is high at a clock edge, `q_o` becomes 0000 after that edge.
- R2: `q_o[0]` (weight 1) inverts once for each high-to-low transition of `cnt_a_i`. A low-to-high transition leaves it unchanged. The change appears within five system clocks of the transition.
- R3: With `link_i` low, each high-to-low transition of `cnt_b_i` moves `q_o[3:1]` through the sequence 000, 001, 010, 011, 100 and back to 000. The bits of `q_o[3:1]` carry weights 2, 4 and 8, and their value never exceeds 100.
- R4: With `link_i` low, `q_o[3]` is high after exactly one of every five consecutive `cnt_b_i` falls, giving a 4:1 low-to-high ratio.
- R5: With `link_i` low, `cnt_a_i` transitions never change `q_o[3:1]`, and `cnt_b_i` transitions never change `q_o[0]`.
- R6: With `link_i` high, each `cnt_a_i` fall advances `q_o` as a BCD digit, 0000 through 1001, then wraps to 0000. In this mode `cnt_b_i` has no effect, and `q_o` never exceeds 1001.
- R7: When `preset0_i` and `preset1_i` are both high at a clock edge, `q_o` is 1001 after that edge, whatever its earlier value. One of them high alone has no effect.
- R8: When `clear0_i` and `clear1_i` are both high and the preset pair is not both high, `q_o` is 0000 after that clock edge. One of them high alone has no effect.
- R9: When both pairs are fully asserted on the same edge, the preset to 1001 takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_a_i | input | 1 | Asynchronous count input of the binary section |
| cnt_b_i | input | 1 | Asynchronous count input of the five-state section |
| link_i | input | 1 | 1: binary bit falling steps the five-state section; 0: `cnt_b_i` steps it |
| clear0_i | input | 1 | Clear pair, first member |
| clear1_i | input | 1 | Clear pair, second member |
| preset0_i | input | 1 | Preset-to-nine pair, first member |
| preset1_i | input | 1 | Preset-to-nine pair, second member |
| q_o | output | 4 | Count, 8421 weights, bit 0 weight 1 |

## Verification
The bound checker examines every cycle for the following:
- the reset result;
- the forced values of the preset and clear pairs, and the priority between them;
- the upper three bits never leaving the range 0 to 4;
- the full digit never exceeding nine;
- each change of the upper bits, outside an override, being exactly one step of the five-state sequence.

Only the bench's scenarios can show the rest:
- that edges on the count inputs produce the right number of steps in the right section;
- that rising edges and the unused input are ignored;
- the 4:1 pattern of the top bit;
- the BCD wrap from nine to zero in linked mode.

// File: rtl/decade_pkg.sv
package decade_pkg;

    localparam int unsigned QUIN_MOD = 5;
    localparam int unsigned QUIN_W   = $clog2(QUIN_MOD);
    localparam int unsigned DIGIT_W  = QUIN_W + 1;

    typedef enum logic [1:0] {
        FORCE_NONE = 2'd0,
        FORCE_ZERO = 2'd1,
        FORCE_NINE = 2'd2
    } force_e;

    typedef struct packed {
        logic [QUIN_W-1:0] quin;
        logic              bi;
    } digit_t;

    function automatic force_e decode_force(input logic c0, input logic c1,
                                            input logic p0, input logic p1);
        force_e f;
        if (p0 && p1)       f = FORCE_NINE;
        else if (c0 && c1)  f = FORCE_ZERO;
        else                f = FORCE_NONE;
        return f;
    endfunction

    function automatic logic [QUIN_W-1:0] quin_advance(input logic [QUIN_W-1:0] v);
        logic [QUIN_W-1:0] n;
        if (v == QUIN_W'(QUIN_MOD - 1)) n = '0;
        else                            n = v + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/fall_sync.sv
module fall_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    localparam int unsigned LAST = SYNC_STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], pin_i};
    end

    assign fall_o = chain[LAST] & ~chain[LAST-1];
endmodule

// File: rtl/bi_section.sv
module bi_section
    import decade_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step_i,
    input  force_e force_i,
    output logic   q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= 1'b0;
        end else begin
            unique case (force_i)
                FORCE_NINE: q_o <= 1'b1;
                FORCE_ZERO: q_o <= 1'b0;
                default:    if (step_i) q_o <= ~q_o;
            endcase
        end
    end
endmodule

// File: rtl/quin_section.sv
module quin_section
    import decade_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  force_e            force_i,
    output logic [QUIN_W-1:0] q_o
);
    localparam logic [QUIN_W-1:0] TOP_STATE = QUIN_W'(QUIN_MOD - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else begin
            unique case (force_i)
                FORCE_NINE: q_o <= TOP_STATE;
                FORCE_ZERO: q_o <= '0;
                default:    if (step_i) q_o <= quin_advance(q_o);
            endcase
        end
    end
endmodule

// File: rtl/decade_ripple_ctr.sv
module decade_ripple_ctr
    import decade_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_a_i,
    input  logic               cnt_b_i,
    input  logic               link_i,
    input  logic               clear0_i,
    input  logic               clear1_i,
    input  logic               preset0_i,
    input  logic               preset1_i,
    output logic [DIGIT_W-1:0] q_o
);
    logic   fall_a;
    logic   fall_b;
    logic   step_quin;
    force_e force_cmd;
    digit_t st;

    fall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst(rst), .pin_i(cnt_a_i), .fall_o(fall_a)
    );

    fall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst(rst), .pin_i(cnt_b_i), .fall_o(fall_b)
    );

    assign force_cmd = decode_force(clear0_i, clear1_i, preset0_i, preset1_i);

    // Linked: binary bit about to fall steps the five-state section.
    assign step_quin = link_i ? (fall_a & st.bi) : fall_b;

    bi_section u_bi (
        .clk(clk), .rst(rst), .step_i(fall_a), .force_i(force_cmd), .q_o(st.bi)
    );

    quin_section u_quin (
        .clk(clk), .rst(rst), .step_i(step_quin), .force_i(force_cmd), .q_o(st.quin)
    );

    assign q_o = st;
endmodule

// File: rtl/decade_ripple_chk.sv
module decade_ripple_chk
    import decade_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               link_i,
    input logic               clear0_i,
    input logic               clear1_i,
    input logic               preset0_i,
    input logic               preset1_i,
    input logic [DIGIT_W-1:0] q_o
);
    logic nine_req;
    logic zero_req;
    assign nine_req = preset0_i && preset1_i;
    assign zero_req = clear0_i && clear1_i;

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> q_o == 4'd0);

    p_quin_range_r3: assert property (@(posedge clk) disable iff (rst)
        q_o[3:1] <= 3'd4);

    p_quin_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!nine_req && !zero_req) |=>
            ((q_o[3:1] == $past(q_o[3:1])) ||
             (q_o[3:1] == (($past(q_o[3:1]) == 3'd4) ? 3'd0 : $past(q_o[3:1]) + 3'd1))));

    p_bcd_limit_r6: assert property (@(posedge clk) disable iff (rst)
        link_i |-> q_o <= 4'd9);

    p_preset_nine_r7: assert property (@(posedge clk) disable iff (rst)
        nine_req |=> q_o == 4'd9);

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (zero_req && !nine_req) |=> q_o == 4'd0);

    p_preset_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (zero_req && nine_req) |=> q_o == 4'd9);
endmodule

bind decade_ripple_ctr decade_ripple_chk u_chk (
    .clk(clk), .rst(rst), .link_i(link_i),
    .clear0_i(clear0_i), .clear1_i(clear1_i),
    .preset0_i(preset0_i), .preset1_i(preset1_i),
    .q_o(q_o)
);

// File: tb/test_decade_ripple_ctr.sv
module test_decade_ripple_ctr;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_a = 1'b0, cnt_b = 1'b0, link = 1'b0;
    logic c0 = 1'b0, c1 = 1'b0, p0 = 1'b0, p1 = 1'b0;
    logic [3:0] q;

    int errors = 0;
    int checks = 0;
    logic       m_bi   = 1'b0;
    logic [2:0] m_quin = 3'd0;

    always #5 clk = ~clk;

    decade_ripple_ctr i_decade_ripple_ctr (
        .clk(clk), .rst(rst), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b), .link_i(link),
        .clear0_i(c0), .clear1_i(c1), .preset0_i(p0), .preset1_i(p1), .q_o(q)
    );

    function automatic logic [2:0] nxt5(input logic [2:0] v);
        return (v == 3'd4) ? 3'd0 : v + 3'd1;
    endfunction

    function automatic logic [3:0] expect_q();
        return {m_quin, m_bi};
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", tag, q, exp);
        end
    endtask

    // R2 R5 R6: full low-high-low pulse on count input A
    task automatic pulse_a();
        @(negedge clk) cnt_a = 1'b1;
        repeat (4) @(negedge clk);
        if (link && m_bi) m_quin = nxt5(m_quin);
        m_bi = ~m_bi;
        cnt_a = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // R3 R5 R6: pulse on count input B
    task automatic pulse_b();
        @(negedge clk) cnt_b = 1'b1;
        repeat (4) @(negedge clk);
        if (!link) m_quin = nxt5(m_quin);
        cnt_b = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic drive_force(input logic a0, input logic a1,
                               input logic b0, input logic b1);
        @(negedge clk);
        c0 = a0; c1 = a1; p0 = b0; p1 = b1;
        if (b0 && b1) begin m_bi = 1'b1; m_quin = 3'd4; end
        else if (a0 && a1) begin m_bi = 1'b0; m_quin = 3'd0; end
        @(negedge clk);
        c0 = 1'b0; c1 = 1'b0; p0 = 1'b0; p1 = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: q=%b expected completion", q);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", 4'd0);

        // R2: rising edge alone ignored, then toggle
        @(negedge clk) cnt_a = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 rise ignored", 4'd0);
        cnt_a = 1'b0;
        m_bi = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 toggle", expect_q());

        // R3 R4 R5: five B pulses, unlinked
        for (int k = 0; k < 5; k++) begin
            pulse_b();
            check("R3/R4 quin step", expect_q());
            checks++;
            if (q[3] !== (k == 3)) begin
                errors++;
                $display("FAIL R4: q3=%b expected %b", q[3], (k == 3));
            end
        end
        pulse_a();
        check("R5 A leaves upper", expect_q());

        // R6: linked BCD from 0 through wrap
        drive_force(1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 clear", 4'd0);
        link = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            pulse_a();
            check("R6 bcd", 4'(k % 10));
        end
        pulse_b();
        check("R6 B ignored when linked", expect_q());

        // R7 R8 R9 single members and priority
        drive_force(1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 single preset ignored", expect_q());
        drive_force(1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 single clear ignored", expect_q());
        drive_force(1'b0, 1'b0, 1'b1, 1'b1);
        check("R7 preset nine", 4'd9);
        pulse_a();
        check("R6 wrap from preset", 4'd0);
        drive_force(1'b1, 1'b1, 1'b1, 1'b1);
        check("R9 preset wins", 4'd9);

        // Random mix
        for (int n = 0; n < 250; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1, 2: begin pulse_a(); check("R2/R5/R6 random A", expect_q()); end
                3, 4, 5: begin pulse_b(); check("R3/R5/R6 random B", expect_q()); end
                6: begin @(negedge clk) link = ~link; check("R6 link change", expect_q()); end
                7: begin drive_force(1'b1, 1'b1, 1'b0, 1'b0); check("R8 random clear", expect_q()); end
                8: begin drive_force(1'b0, 1'b0, 1'b1, 1'b1); check("R7 random preset", expect_q()); end
                default: begin
                    drive_force(1'($urandom_range(0, 1)), 1'b0, 1'b0, 1'($urandom_range(0, 1)));
                    check("R7/R8 random single member", expect_q());
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule